// File: doc/BRIEF.md
# Windowed Watchdog with Warning Interrupt

The block is a window watchdog counter clocked from a slow low-power clock. Once enabled it counts up by one per cycle and must be serviced inside a window. Servicing too early, below the early limit, can raise a reset request. Letting the count reach the late limit stops the counter and can also raise a reset request. A third compare point, the warning limit, sets a sticky interrupt. With auto-service that point can also restart the count, which turns the block into a periodic tick source when it is not being used as a watchdog.

A 32-bit configuration word chooses the actions and the pause behaviour. The counter can be held while the chip sleeps, while it hibernates, or while a debugger is attached. The debug hold can be gated by an external halt trigger, or the counter can keep running under the debugger with reset generation blocked. The debug, trigger and sleep inputs are resynchronised through two flip-flop stages. After any sleep, hibernate or debug episode, the early-service check stays off until the first service.

Top module: `wwdg_top`

## Requirements
- R1: Configuration word bit positions: bit 0 enables the early-service reset, bit 4 the late-limit reset, bit 8 the warning interrupt, bit 12 auto-service, bit 28 trigger gating of the debug hold, bit 29 the deep-sleep hold, bit 30 the hibernate hold and bit 31 debug-run. The word 0x10 enables only the late-limit reset.
- R2: While enabled and not held, the count rises by one on each clock edge. A service pulse makes it zero on the next edge. With the enable low, the count is zero and both the reset request and the interrupt are low from the next edge onward.
- R3: The count stops at the late limit whatever the configuration. With the late-limit reset enabled, rst_req_o is high for exactly one cycle, starting on the edge where the count reaches a limit of 2 or more.
- R4: A service while the count is below a nonzero early limit, with the early-service reset enabled, raises rst_req_o for one cycle on the next edge. An early limit of zero, or a service at or above the limit, raises nothing.
- R5: With the warning interrupt enabled, irq_o is set on the edge where the count reaches a warning limit of 1 or more. It stays set until a cycle with irq_clr_i high and no new warning event. Set takes priority over clear.
- R6: With auto-service on and both reset actions off, the count restarts from zero after it equals the warning limit, giving a period of warning limit plus one cycles. With either reset action enabled, auto-service has no effect.
- R7: A warning limit of zero raises the interrupt once after enabling and never again while the count stays at zero.
- R8: With debug-run clear, an attached debugger holds the count. With trigger gating set, the hold applies only while the halt trigger is also high.
- R9: With debug-run set, the count keeps advancing under a debugger and stops at the late limit, but no reset request is raised.
- R10: With the matching hold bit set, deep sleep or hibernate holds the count. During either state, and under a debugger, an early service raises no reset.
- R11: After deep sleep, hibernate or a debugger session ends, the first service performs no early check. Later services are checked as configured.
- R12: Hold inputs pass through two synchronising stages. Once a hold input rises, the count still advances on exactly two more edges. Once it falls, the count stays unchanged for two more edges and resumes on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow counter clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_en_i | input | 1 | Counter enable |
| kick_i | input | 1 | Service strobe, one cycle |
| cfg_i | input | 32 | Configuration word |
| early_lim_i | input | CNT_W | Earliest allowed service count |
| late_lim_i | input | CNT_W | Latest allowed count, counter stops here |
| warn_lim_i | input | CNT_W | Warning interrupt / auto-service point |
| dbg_conn_i | input | 1 | Debugger attached, asynchronous |
| halt_trig_i | input | 1 | External halt trigger, asynchronous |
| deep_sleep_i | input | 1 | Chip in deep sleep, asynchronous |
| hibernate_i | input | 1 | Chip in hibernate, asynchronous |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt |
| rst_req_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Sticky warning interrupt |
| count_o | output | CNT_W | Current count |

## Verification
On every cycle the assertions check several properties. The disabled state is quiet. The count never moves once it sits at or above the late limit. Every reset request follows either a service or a count at the late limit. The interrupt stays set until it is cleared. Three cycles after a debugger appears, the count is frozen when debug-run and gating are off and reset requests are absent. Some behaviours are only visible in the directed scenarios: the exact edge on which each action fires, the two-edge synchronizer lag in both directions, the auto-service period, the single firing for a zero warning limit, the sleep and hibernate holds, and the skip of the early check on the first service after a pause.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

    localparam int unsigned CFG_W = 32;

    // Field positions inside the configuration word (decoded by the register neighbour)
    localparam int unsigned BIT_EARLY = 0;
    localparam int unsigned BIT_LATE  = 4;
    localparam int unsigned BIT_WARN  = 8;
    localparam int unsigned BIT_AUTO  = 12;
    localparam int unsigned BIT_TRIG  = 28;
    localparam int unsigned BIT_DSLP  = 29;
    localparam int unsigned BIT_HIB   = 30;
    localparam int unsigned BIT_RUN   = 31;

    // Environment inputs, in synchronizer lane order
    localparam int unsigned ENV_N = 4;

    // Compare watchers
    localparam int unsigned WATCH_WARN = 0;
    localparam int unsigned WATCH_LATE = 1;
    localparam int unsigned WATCH_N    = 2;

    typedef struct packed {
        logic early_rst;
        logic late_rst;
        logic warn_irq;
        logic auto_kick;
        logic trig_gate;
        logic dslp_hold;
        logic hib_hold;
        logic dbg_run;
    } wdg_mode_t;

    typedef struct packed {
        logic dbg;
        logic trig;
        logic dslp;
        logic hib;
    } wdg_env_t;

    function automatic wdg_mode_t decode_cfg(input logic [CFG_W-1:0] w);
        wdg_mode_t m;
        m.early_rst = w[BIT_EARLY];
        m.late_rst  = w[BIT_LATE];
        m.warn_irq  = w[BIT_WARN];
        m.auto_kick = w[BIT_AUTO];
        m.trig_gate = w[BIT_TRIG];
        m.dslp_hold = w[BIT_DSLP];
        m.hib_hold  = w[BIT_HIB];
        m.dbg_run   = w[BIT_RUN];
        return m;
    endfunction

endpackage

// File: rtl/wwdg_sync2.sv
module wwdg_sync2 #(
    parameter int unsigned N      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wwdg_mode_ctrl.sv
module wwdg_mode_ctrl
    import wwdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wdg_mode_t        mode,
    input  logic [ENV_N-1:0] env_raw,
    input  logic             kick,
    output logic             hold,
    output logic             early_ok,
    output logic             late_ok
);
    logic [ENV_N-1:0] env_q;
    wdg_env_t         env_s;
    logic             dbg_hold, sleep_hold, disturbed, supp_q;

    wwdg_sync2 #(.N(ENV_N), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (env_raw),
        .q   (env_q)
    );

    assign env_s = wdg_env_t'(env_q);

    // Debugger hold, optionally gated by the halt trigger
    assign dbg_hold   = env_s.dbg && !mode.dbg_run && (!mode.trig_gate || env_s.trig);
    assign sleep_hold = (env_s.dslp && mode.dslp_hold) || (env_s.hib && mode.hib_hold);
    assign hold       = dbg_hold || sleep_hold;

    // Any low-power or debug episode disarms the early check until a service
    assign disturbed = env_s.dbg || env_s.dslp || env_s.hib;

    always_ff @(posedge clk) begin
        if (rst)            supp_q <= 1'b0;
        else if (disturbed) supp_q <= 1'b1;
        else if (kick)      supp_q <= 1'b0;
    end

    assign early_ok = !disturbed && !supp_q;
    assign late_ok  = !env_s.dbg;
endmodule

// File: rtl/wwdg_counter.sv
module wwdg_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             kick,
    input  logic             hold,
    input  logic [CNT_W-1:0] late_lim,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nx,
    output logic             adv
);
    logic at_top;

    assign at_top = count_q >= late_lim;
    assign adv    = en && !kick && !hold && !at_top;

    always_comb begin
        if (!en || kick) count_nx = '0;
        else if (adv)    count_nx = count_q + 1'b1;
        else             count_nx = count_q;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_nx;
    end
endmodule

// File: rtl/wwdg_limit_watch.sv
module wwdg_limit_watch #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             act,
    input  logic             adv,
    input  logic [CNT_W-1:0] count_q,
    input  logic [CNT_W-1:0] count_nx,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    logic seen_q;

    // Fires on the edge the count steps onto the limit; otherwise one
    // cycle after the count is found sitting on it unannounced.
    assign fire = en && act &&
                  ((adv && (count_nx == limit)) || ((count_q == limit) && !seen_q));

    always_ff @(posedge clk) begin
        if (rst || !en)              seen_q <= 1'b0;
        else if (fire)               seen_q <= 1'b1;
        else if (count_nx != limit)  seen_q <= 1'b0;
    end
endmodule

// File: rtl/wwdg_top.sv
module wwdg_top
    import wwdg_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_en_i,
    input  logic             kick_i,
    input  logic [31:0]      cfg_i,
    input  logic [CNT_W-1:0] early_lim_i,
    input  logic [CNT_W-1:0] late_lim_i,
    input  logic [CNT_W-1:0] warn_lim_i,
    input  logic             dbg_conn_i,
    input  logic             halt_trig_i,
    input  logic             deep_sleep_i,
    input  logic             hibernate_i,
    input  logic             irq_clr_i,
    output logic             rst_req_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] count_o
);
    wdg_mode_t                     mode;
    wdg_env_t                      env_raw;
    logic                          hold, early_ok, late_ok;
    logic                          auto_kick, kick, adv, early_fire;
    logic [CNT_W-1:0]              count_q, count_nx;
    logic [WATCH_N-1:0][CNT_W-1:0] lim;
    logic [WATCH_N-1:0]            act, fire;
    logic                          rst_q, irq_q;

    assign mode = decode_cfg(cfg_i);

    assign env_raw.dbg  = dbg_conn_i;
    assign env_raw.trig = halt_trig_i;
    assign env_raw.dslp = deep_sleep_i;
    assign env_raw.hib  = hibernate_i;

    wwdg_mode_ctrl u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .env_raw  (env_raw),
        .kick     (kick),
        .hold     (hold),
        .early_ok (early_ok),
        .late_ok  (late_ok)
    );

    // Periodic self-service only when the counter is not a watchdog
    assign auto_kick = wd_en_i && mode.auto_kick && !mode.early_rst && !mode.late_rst &&
                       !hold && (count_q == warn_lim_i);
    assign kick      = kick_i || auto_kick;

    wwdg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (wd_en_i),
        .kick     (kick),
        .hold     (hold),
        .late_lim (late_lim_i),
        .count_q  (count_q),
        .count_nx (count_nx),
        .adv      (adv)
    );

    assign early_fire = wd_en_i && kick_i && mode.early_rst && early_ok &&
                        (early_lim_i != '0) && (count_q < early_lim_i);

    assign lim[WATCH_WARN] = warn_lim_i;
    assign act[WATCH_WARN] = mode.warn_irq;
    assign lim[WATCH_LATE] = late_lim_i;
    assign act[WATCH_LATE] = mode.late_rst && late_ok;

    for (genvar g = 0; g < WATCH_N; g++) begin : g_watch
        wwdg_limit_watch #(.CNT_W(CNT_W)) u_watch (
            .clk      (clk),
            .rst      (rst),
            .en       (wd_en_i),
            .act      (act[g]),
            .adv      (adv),
            .count_q  (count_q),
            .count_nx (count_nx),
            .limit    (lim[g]),
            .fire     (fire[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !wd_en_i) begin
            rst_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            rst_q <= early_fire || fire[WATCH_LATE];
            if (fire[WATCH_WARN]) irq_q <= 1'b1;
            else if (irq_clr_i)   irq_q <= 1'b0;
        end
    end

    assign rst_req_o = rst_q;
    assign irq_o     = irq_q;
    assign count_o   = count_q;
endmodule

// File: rtl/wwdg_top_chk.sv
module wwdg_top_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wd_en_i,
    input logic             kick_i,
    input logic [31:0]      cfg_i,
    input logic [CNT_W-1:0] late_lim_i,
    input logic             dbg_conn_i,
    input logic             irq_clr_i,
    input logic             rst_req_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] count_o
);
    logic [2:0] age;
    logic       settled;

    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end
    assign settled = age > 3'd4;

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !wd_en_i |=> (count_o == '0 && !rst_req_o && !irq_o));

    assert_stop_at_top_R3: assert property (@(posedge clk) disable iff (rst)
        (wd_en_i && !kick_i && count_o >= late_lim_i) |=>
        (count_o == $past(count_o) || count_o == '0));

    assert_reset_cause_R4: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($past(kick_i) || count_o >= late_lim_i));

    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_o && wd_en_i && !irq_clr_i) |=> irq_o);

    assert_dbg_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(dbg_conn_i, 3) &&
         $past(wd_en_i && !kick_i && !cfg_i[31] && !cfg_i[28])) |->
        count_o == $past(count_o));

    assert_dbg_no_reset_R9: assert property (@(posedge clk) disable iff (rst)
        (settled && $past(dbg_conn_i, 3)) |-> !rst_req_o);
endmodule

bind wwdg_top wwdg_top_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wd_en_i    (wd_en_i),
    .kick_i     (kick_i),
    .cfg_i      (cfg_i),
    .late_lim_i (late_lim_i),
    .dbg_conn_i (dbg_conn_i),
    .irq_clr_i  (irq_clr_i),
    .rst_req_o  (rst_req_o),
    .irq_o      (irq_o),
    .count_o    (count_o)
);

// File: tb/wwdg_top_tb.sv
module wwdg_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wd_en_i = 1'b0, kick_i = 1'b0, irq_clr_i = 1'b0;
    logic [31:0]      cfg_i = 32'h0;
    logic [CNT_W-1:0] early_lim_i = '0, late_lim_i = '0, warn_lim_i = '0;
    logic             dbg_conn_i = 1'b0, halt_trig_i = 1'b0, deep_sleep_i = 1'b0, hibernate_i = 1'b0;
    logic             rst_req_o, irq_o;
    logic [CNT_W-1:0] count_o;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wwdg_top #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .wd_en_i(wd_en_i), .kick_i(kick_i), .cfg_i(cfg_i),
        .early_lim_i(early_lim_i), .late_lim_i(late_lim_i), .warn_lim_i(warn_lim_i),
        .dbg_conn_i(dbg_conn_i), .halt_trig_i(halt_trig_i), .deep_sleep_i(deep_sleep_i),
        .hibernate_i(hibernate_i), .irq_clr_i(irq_clr_i),
        .rst_req_o(rst_req_o), .irq_o(irq_o), .count_o(count_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Disable, clear any suppression with a service, load settings, enable.
    // After this, k more negedges give count k.
    task automatic arm(input logic [31:0] cfg, input int early, input int late, input int warn);
        wd_en_i = 1'b0; kick_i = 1'b1;
        step(1);
        kick_i = 1'b0;
        cfg_i = cfg;
        early_lim_i = CNT_W'(early); late_lim_i = CNT_W'(late); warn_lim_i = CNT_W'(warn);
        wd_en_i = 1'b1;
    endtask

    task automatic pulse_kick();
        kick_i = 1'b1; step(1); kick_i = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R2 reset count", int'(count_o), 0);
        chk("R2 reset rst_req", int'(rst_req_o), 0);
        chk("R2 reset irq", int'(irq_o), 0);
    endtask

    task automatic t_count_and_kick();
        arm(32'h0, 0, 200, 0);
        step(5);  chk("R2 counts up", int'(count_o), 5);
        pulse_kick(); chk("R2 service clears", int'(count_o), 0);
        step(3);  chk("R2 counts after service", int'(count_o), 3);
        wd_en_i = 1'b0; step(1);
        chk("R2 disable zeroes count", int'(count_o), 0);
        step(2);  chk("R2 disable holds zero", int'(count_o), 0);
    endtask

    task automatic t_late_timeout();
        int pulses = 0; int hit = -1;
        arm(32'h0000_0010, 0, 20, 0);   // R1 reset value enables late reset only
        for (int i = 0; i < 25; i++) begin
            step(1);
            if (rst_req_o) begin pulses++; if (hit < 0) hit = int'(count_o); end
        end
        chk("R3 single reset pulse", pulses, 1);
        chk("R3 pulse on reaching limit", hit, 20);
        chk("R3 count stops at limit", int'(count_o), 20);
        cfg_i = 32'h0; step(3);
        chk("R3 stops without action", int'(count_o), 20);
    endtask

    task automatic t_early_service();
        arm(32'h0000_0011, 8, 100, 0);
        step(3); pulse_kick();
        chk("R4 early service resets", int'(rst_req_o), 1);
        chk("R4 early service clears count", int'(count_o), 0);
        step(1); chk("R4 reset is one cycle", int'(rst_req_o), 0);
        arm(32'h0000_0011, 8, 100, 0);
        step(10); pulse_kick();
        chk("R4 in-window service quiet", int'(rst_req_o), 0);
        arm(32'h0000_0011, 0, 100, 0);
        step(3); pulse_kick();
        chk("R4 zero early limit quiet", int'(rst_req_o), 0);
    endtask

    task automatic t_warn_irq();
        arm(32'h0000_0110, 0, 100, 6);
        step(5); chk("R5 no irq before warn", int'(irq_o), 0);
        step(1); chk("R5 irq on reaching warn", int'(irq_o), 1);
        step(3); chk("R5 irq sticky", int'(irq_o), 1);
        irq_clr_i = 1'b1; step(1); irq_clr_i = 1'b0;
        chk("R5 irq cleared", int'(irq_o), 0);
    endtask

    task automatic t_auto_service();
        int bad = 0; int highs = 0;
        arm(32'h0000_1100, 0, 200, 4);
        for (int k = 1; k <= 20; k++) begin
            step(1);
            if (int'(count_o) != k % 5) bad++;
        end
        chk("R6 auto period warn+1", bad, 0);
        arm(32'h0000_1100, 0, 200, 1);
        step(4);
        irq_clr_i = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (irq_o) highs++;
        end
        irq_clr_i = 1'b0;
        chk("R6 periodic irq at warn 1", highs, 5);
        arm(32'h0000_1110, 0, 50, 4);
        step(10); chk("R6 auto ignored with reset action", int'(count_o), 10);
    endtask

    task automatic t_warn_zero();
        arm(32'h0000_1100, 0, 200, 0);
        step(1); chk("R7 warn zero fires", int'(irq_o), 1);
        irq_clr_i = 1'b1; step(1); irq_clr_i = 1'b0;
        step(10); chk("R7 warn zero fires once", int'(irq_o), 0);
        chk("R7 count held at zero", int'(count_o), 0);
    endtask

    task automatic t_debug_hold();
        arm(32'h0000_0010, 0, 100, 0);
        step(5); dbg_conn_i = 1'b1;
        step(2); chk("R12 two edges of lag on hold", int'(count_o), 7);
        step(4); chk("R8 debugger holds count", int'(count_o), 7);
        dbg_conn_i = 1'b0;
        step(2); chk("R12 still held two edges", int'(count_o), 7);
        step(1); chk("R12 resumes on third edge", int'(count_o), 8);
        arm(32'h1000_0010, 0, 100, 0);
        dbg_conn_i = 1'b1;
        step(6); chk("R8 gated hold needs trigger", int'(count_o), 6);
        halt_trig_i = 1'b1;
        step(2); chk("R8 trigger lag", int'(count_o), 8);
        step(3); chk("R8 trigger holds count", int'(count_o), 8);
        halt_trig_i = 1'b0; dbg_conn_i = 1'b0; step(4);
    endtask

    task automatic t_debug_run();
        int pulses = 0;
        dbg_conn_i = 1'b1; step(3);
        arm(32'h8000_0010, 0, 10, 0);
        for (int i = 0; i < 15; i++) begin
            step(1);
            if (rst_req_o) pulses++;
        end
        chk("R9 debug-run blocks reset", pulses, 0);
        chk("R9 debug-run counts to limit", int'(count_o), 10);
        wd_en_i = 1'b0; dbg_conn_i = 1'b0; step(4);
    endtask

    task automatic t_sleep_hold();
        arm(32'h2000_0010, 0, 100, 0);
        step(4); deep_sleep_i = 1'b1;
        step(2); chk("R12 sleep lag", int'(count_o), 6);
        step(3); chk("R10 deep sleep holds", int'(count_o), 6);
        deep_sleep_i = 1'b0; step(3);
        chk("R10 resumes after sleep", int'(count_o), 7);
        arm(32'h4000_0010, 0, 100, 0);
        step(4); hibernate_i = 1'b1;
        step(5); chk("R10 hibernate holds", int'(count_o), 6);
        hibernate_i = 1'b0; step(4);
        arm(32'h0000_0010, 0, 100, 0);
        hibernate_i = 1'b1;
        step(6); chk("R10 hibernate runs when hold off", int'(count_o), 6);
        hibernate_i = 1'b0; step(4);
    endtask

    task automatic t_suppression();
        arm(32'h0000_0011, 50, 200, 0);
        deep_sleep_i = 1'b1;
        step(4); pulse_kick();
        chk("R10 early check off in sleep", int'(rst_req_o), 0);
        deep_sleep_i = 1'b0; step(4);
        pulse_kick();
        chk("R11 first service after sleep quiet", int'(rst_req_o), 0);
        step(2); pulse_kick();
        chk("R11 next early service resets", int'(rst_req_o), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset_state();
        t_count_and_kick();
        t_late_timeout();
        t_early_service();
        t_warn_irq();
        t_auto_service();
        t_warn_zero();
        t_debug_hold();
        t_debug_run();
        t_sleep_hold();
        t_suppression();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule